// File: doc/BRIEF.md
# Hint-Filtered Pointer Scanning Prefetcher

This block sits beside a cache fill path. When a line arrives it takes the line's virtual address, its data, the byte offset that the triggering load touched, a hint bit vector carried with that load, and the depth of the request that brought the line in. It treats every aligned 32-bit word of the line as a possible virtual address. A word counts as a pointer when its top compare bits equal the same bits of the line address.

A pointer is not prefetched just because it looks like an address. Its word position, counted from the word the load touched, must select a set bit in the hint vector. Its new depth, which is the line's depth plus one, must not exceed a maximum that a throttle input sets. The prefetches that pass both tests go out one per handshake on a valid/ready port. Each carries its depth, so a line fetched by one of these prefetches can be scanned again at the next depth.

While a line is being scanned the block holds its input ready low. It accepts the next line only after the last prefetch of the current one has been taken.

Top module: `hint_ptr_prefetch`

## Requirements
- R1: A word is a pointer candidate only when its upper CMP_BITS bits (default 8) equal the upper CMP_BITS bits of `in_line_addr`.
- R2: The accessed word index is `in_byte_off >> 2`. Hint bit i selects the word at index (accessed word + i). A candidate whose hint bit is clear generates no prefetch. A candidate whose hint bit is set does generate one, unless R5 or R7 suppresses it.
- R3: Words below the accessed word, and words at an index of accessed word + HINT_W or above (default HINT_W = 12), are never prefetched.
- R4: Every prefetch of a line carries `pf_depth` equal to `in_depth` + 1. A demand line (depth 0) therefore yields depth 1.
- R5: When `in_depth` + 1 is greater than `max_depth` as sampled at line acceptance, the line generates no prefetch. Later changes to `max_depth` do not affect a scan that has already started.
- R6: `pf_addr` is the candidate word with its low log2(LINE_BYTES) bits cleared (LINE_BYTES defaults to 64).
- R7: A candidate whose line-aligned address equals the line-aligned `in_line_addr` is dropped.
- R8: Prefetches of one line leave in ascending word order, one per cycle in which `pf_valid` and `pf_ready` are both high. While `pf_ready` is low, `pf_valid`, `pf_addr` and `pf_depth` hold.
- R9: A line is accepted on a cycle in which `in_valid` and `in_ready` are both high. `in_ready` is low from the cycle after acceptance until the last prefetch has been taken. A line with no qualifying word returns `in_ready` high in the cycle after acceptance. `in_valid` is ignored while `in_ready` is low.
- R10: A synchronous active-high `rst` clears any scan in progress: after the reset edge `pf_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Filled line offered |
| in_ready | output | 1 | Block can accept a line |
| in_line_addr | input | 32 | Virtual address of the line |
| in_line_data | input | 512 | Line data, word w at bits [32w+31:32w] |
| in_byte_off | input | 6 | Byte within the line touched by the load |
| in_hint | input | 12 | Per-load hint vector, bit i = accessed word + i |
| in_depth | input | 3 | Depth of the request that fetched the line |
| max_depth | input | 3 | Throttle: largest depth allowed for a prefetch |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Consumer takes the prefetch |
| pf_addr | output | 32 | Line-aligned prefetch address |
| pf_depth | output | 3 | Depth of the prefetch |

## Verification
The block keeps a pending-word mask and the captured line. A bit left set or cleared wrongly in that mask shows up at the port as an extra prefetch, a missing prefetch, or one out of ascending order. These errors appear within a handshake of the point where that word should have been emitted. A pending mask that never empties holds `in_ready` low indefinitely, so the next line is never accepted. A stale captured address or depth shows on the first `pf_addr` or `pf_depth` of the scan. The captured throttle limit is tested by changing `max_depth` in the middle of a scan.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  // Default sizes shared by the prefetcher and its checker
  localparam int DEF_ADDR_W     = 32;
  localparam int DEF_LINE_BYTES = 64;
  localparam int DEF_CMP_BITS   = 8;
  localparam int DEF_HINT_W     = 12;
  localparam int DEF_DEPTH_W    = 3;
endpackage

// File: rtl/hfp_word_qualify.sv
// Marks each word of a line that should become a prefetch
module hfp_word_qualify #(
  parameter int ADDR_W     = hfp_pkg::DEF_ADDR_W,
  parameter int LINE_BYTES = hfp_pkg::DEF_LINE_BYTES,
  parameter int CMP_BITS   = hfp_pkg::DEF_CMP_BITS,
  parameter int HINT_W     = hfp_pkg::DEF_HINT_W,
  localparam int WORDS     = LINE_BYTES / (ADDR_W / 8),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int WSH       = $clog2(ADDR_W / 8)
) (
  input  logic [ADDR_W-1:0]       line_addr,
  input  logic [LINE_BYTES*8-1:0] line_data,
  input  logic [OFF_W-1:0]        byte_off,
  input  logic [HINT_W-1:0]       hint,
  input  logic                    depth_ok,
  output logic [WORDS-1:0]        keep
);
  localparam int EXT_W = WORDS + HINT_W;

  logic [OFF_W-WSH-1:0] acc_word;
  logic [EXT_W-1:0]     hint_at_word;

  // Move the hint vector so bit i lands on word (accessed word + i);
  // bits falling off the top of the line are discarded
  assign acc_word     = byte_off[OFF_W-1:WSH];
  assign hint_at_word = EXT_W'(hint) << acc_word;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [ADDR_W-1:0] val;
    logic              looks_ptr;
    logic              same_line;
    assign val       = line_data[w*ADDR_W +: ADDR_W];
    assign looks_ptr = val[ADDR_W-1 -: CMP_BITS] == line_addr[ADDR_W-1 -: CMP_BITS];
    assign same_line = val[ADDR_W-1:OFF_W] == line_addr[ADDR_W-1:OFF_W];
    assign keep[w]   = depth_ok & looks_ptr & ~same_line & hint_at_word[w];
  end
endmodule

// File: rtl/hfp_pick_lowest.sv
// Finds the lowest set bit of a pending mask
module hfp_pick_lowest #(
  parameter int N       = 16,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]     mask,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IDX_W'(i);
    end
  end
  assign any = |mask;
endmodule

// File: rtl/hint_ptr_prefetch.sv
module hint_ptr_prefetch #(
  parameter int ADDR_W     = hfp_pkg::DEF_ADDR_W,
  parameter int LINE_BYTES = hfp_pkg::DEF_LINE_BYTES,
  parameter int CMP_BITS   = hfp_pkg::DEF_CMP_BITS,
  parameter int HINT_W     = hfp_pkg::DEF_HINT_W,
  parameter int DEPTH_W    = hfp_pkg::DEF_DEPTH_W,
  localparam int WORDS     = LINE_BYTES / (ADDR_W / 8),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ADDR_W-1:0]       in_line_addr,
  input  logic [LINE_BYTES*8-1:0] in_line_data,
  input  logic [OFF_W-1:0]        in_byte_off,
  input  logic [HINT_W-1:0]       in_hint,
  input  logic [DEPTH_W-1:0]      in_depth,
  input  logic [DEPTH_W-1:0]      max_depth,
  output logic                    pf_valid,
  input  logic                    pf_ready,
  output logic [ADDR_W-1:0]       pf_addr,
  output logic [DEPTH_W-1:0]      pf_depth
);
  logic [LINE_BYTES*8-1:0] line_q;
  logic [ADDR_W-1:0]       addr_q;
  logic [DEPTH_W-1:0]      depth_q;
  logic [WORDS-1:0]        pend_q;
  logic [WORDS-1:0]        keep;
  logic [DEPTH_W:0]        next_depth;
  logic                    depth_ok;
  logic                    pick_any;
  logic [IDX_W-1:0]        pick_idx;
  logic [ADDR_W-1:0]       pick_word;
  logic                    take_line;
  logic                    advance;

  // The depth limit is applied once, when the line is accepted
  assign next_depth = {1'b0, in_depth} + 1'b1;
  assign depth_ok   = next_depth <= {1'b0, max_depth};

  hfp_word_qualify #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .CMP_BITS(CMP_BITS), .HINT_W(HINT_W)
  ) u_qual (
    .line_addr(in_line_addr),
    .line_data(in_line_data),
    .byte_off (in_byte_off),
    .hint     (in_hint),
    .depth_ok (depth_ok),
    .keep     (keep)
  );

  hfp_pick_lowest #(.N(WORDS)) u_pick (
    .mask(pend_q),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign pick_word = line_q[pick_idx*ADDR_W +: ADDR_W];
  assign in_ready  = ~pf_valid & ~(|pend_q);
  assign take_line = in_valid & in_ready;
  assign advance   = ~pf_valid | pf_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      pf_valid <= 1'b0;
      pf_addr  <= '0;
      pf_depth <= '0;
      line_q   <= '0;
      addr_q   <= '0;
      depth_q  <= '0;
    end else if (take_line) begin
      line_q  <= in_line_data;
      addr_q  <= in_line_addr;
      depth_q <= next_depth[DEPTH_W-1:0];
      pend_q  <= keep;
    end else if (advance) begin
      if (pick_any) begin
        pf_valid         <= 1'b1;
        pf_addr          <= {pick_word[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        pf_depth         <= depth_q;
        pend_q[pick_idx] <= 1'b0;
      end else begin
        pf_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hfp_checker.sv
module hfp_checker #(
  parameter int ADDR_W     = hfp_pkg::DEF_ADDR_W,
  parameter int LINE_BYTES = hfp_pkg::DEF_LINE_BYTES,
  parameter int CMP_BITS   = hfp_pkg::DEF_CMP_BITS,
  parameter int DEPTH_W    = hfp_pkg::DEF_DEPTH_W,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input logic               clk,
  input logic               rst,
  input logic               in_ready,
  input logic               pf_valid,
  input logic               pf_ready,
  input logic [ADDR_W-1:0]  pf_addr,
  input logic [DEPTH_W-1:0] pf_depth,
  input logic [ADDR_W-1:0]  line_addr_q
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr) && $stable(pf_depth));

  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> !in_ready);

  assert_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> pf_addr[OFF_W-1:0] == '0);

  assert_tag_match_R1: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> pf_addr[ADDR_W-1 -: CMP_BITS] == line_addr_q[ADDR_W-1 -: CMP_BITS]);

  assert_not_self_R7: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> pf_addr[ADDR_W-1:OFF_W] != line_addr_q[ADDR_W-1:OFF_W]);

  assert_depth_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> pf_depth != '0);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> !pf_valid && in_ready);
endmodule

bind hint_ptr_prefetch hfp_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
  .CMP_BITS(CMP_BITS), .DEPTH_W(DEPTH_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .pf_valid   (pf_valid),
  .pf_ready   (pf_ready),
  .pf_addr    (pf_addr),
  .pf_depth   (pf_depth),
  .line_addr_q(addr_q)
);

// File: tb/hint_ptr_prefetch_tb.sv
module hint_ptr_prefetch_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_line_addr = '0;
  logic [511:0] in_line_data = '0;
  logic [5:0]   in_byte_off = '0;
  logic [11:0]  in_hint = '0;
  logic [2:0]   in_depth = '0;
  logic [2:0]   max_depth = 3'd4;
  logic         pf_valid;
  logic         pf_ready = 1'b1;
  logic [31:0]  pf_addr;
  logic [2:0]   pf_depth;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  hint_ptr_prefetch u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_line_addr(in_line_addr), .in_line_data(in_line_data),
    .in_byte_off(in_byte_off), .in_hint(in_hint), .in_depth(in_depth),
    .max_depth(max_depth), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr), .pf_depth(pf_depth)
  );

  localparam logic [31:0] LINE_A = 32'h8001_1100;

  // Candidates (top byte 0x80): words 1,2,5,7,8,10,11,13,14,15.
  // Word 4 points back into the line itself (R7).
  function automatic logic [31:0] word_val(int i);
    case (i)
      0: return 32'h1234_5678;  1: return 32'h8002_2220;
      2: return 32'h8003_3344;  3: return 32'h0000_0005;
      4: return 32'h8001_1120;  5: return 32'h8004_4404;
      6: return 32'h8100_0000;  7: return 32'h8005_5560;
      8: return 32'h800F_FFFF;  9: return 32'h7FFF_FFFF;
      10: return 32'h8010_0000; 11: return 32'h80AB_CDEF;
      12: return 32'h0000_0000; 13: return 32'h8000_0000;
      14: return 32'h8000_003F; default: return 32'h80FF_FFFF;
    endcase
  endfunction

  // {hint[11:0], byte_off[5:0], depth[2:0], max_depth[2:0], expected word mask[15:0]}
  localparam int NV = 11;
  localparam logic [39:0] VEC [NV] = '{
    {12'hFFF, 6'd0,  3'd0, 3'd4, 16'h0DA6},  // R1 R7 all hints, words 0..11
    {12'h000, 6'd0,  3'd0, 3'd4, 16'h0000},  // R2 no hints
    {12'h844, 6'd0,  3'd0, 3'd4, 16'h0804},  // R2 bits 2,6,11
    {12'hFFF, 6'd20, 3'd0, 3'd4, 16'hEDA0},  // R3 start at word 5
    {12'h003, 6'd32, 3'd1, 3'd4, 16'h0100},  // R3 R4 words 8,9
    {12'h001, 6'd6,  3'd2, 3'd4, 16'h0002},  // R2 unaligned byte -> word 1
    {12'hFFF, 6'd0,  3'd3, 3'd4, 16'h0DA6},  // R5 depth 4 allowed
    {12'hFFF, 6'd0,  3'd4, 3'd4, 16'h0000},  // R5 depth 5 suppressed
    {12'hFFF, 6'd0,  3'd0, 3'd0, 16'h0000},  // R5 throttle at 0
    {12'hFFF, 6'd60, 3'd0, 3'd7, 16'h8000},  // R3 last word only
    {12'hFFF, 6'd16, 3'd6, 3'd7, 16'hEDA0}   // R7 self word 4 dropped, R4 depth 7
  };

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(logic [11:0] hint, logic [5:0] off, logic [2:0] d,
                         logic [2:0] m, logic [15:0] exp, bit intrude);
    logic [15:0] rem = exp;
    bit stalled = 0;
    logic [31:0] held = '0;
    int cyc = 0;
    for (int i = 0; i < 16; i++) in_line_data[i*32 +: 32] = word_val(i);
    in_line_addr = LINE_A; in_hint = hint; in_byte_off = off;
    in_depth = d; max_depth = m; in_valid = 1'b1;
    check(in_ready === 1'b1, "R9 ready before line", {31'b0, in_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready === (exp == 0), "R9 ready after accept", {31'b0, in_ready}, {31'b0, exp == 0});
    while (1) begin
      if (stalled)
        check(pf_valid === 1'b1 && pf_addr === held, "R8 hold while stalled", pf_addr, held);
      if (intrude && cyc < 3) begin
        // R9: offered while busy, must be ignored; R5: throttle change ignored
        in_valid = 1'b1; in_line_addr = 32'h4000_0000; max_depth = 3'd0;
      end else begin
        in_valid = 1'b0; in_line_addr = LINE_A;
      end
      if (!pf_valid && in_ready) break;
      pf_ready = (cyc % 3) != 1;
      cyc++;
      stalled = 0;
      if (pf_valid) begin
        if (pf_ready) begin
          int idx = -1;
          for (int i = 15; i >= 0; i--) if (rem[i]) idx = i;
          if (idx < 0) begin
            check(1'b0, "R2 unexpected prefetch", pf_addr, 32'h0);
          end else begin
            check(pf_addr === (word_val(idx) & 32'hFFFF_FFC0), "R6 R8 address/order",
                  pf_addr, word_val(idx) & 32'hFFFF_FFC0);
            check(pf_depth === d + 3'd1, "R4 depth", {29'b0, pf_depth}, {29'b0, d + 3'd1});
            rem[idx] = 1'b0;
          end
        end else begin
          stalled = 1; held = pf_addr;
        end
      end
      @(negedge clk);
    end
    check(rem == 0, "R2 R3 missing prefetches", {16'b0, rem}, 32'h0);
    max_depth = 3'd4;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pf_valid === 1'b0, "R10 reset pf_valid", {31'b0, pf_valid}, 32'd0);
    check(in_ready === 1'b1, "R10 reset in_ready", {31'b0, in_ready}, 32'd1);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][39:28], VEC[v][27:22], VEC[v][21:19], VEC[v][18:16], VEC[v][15:0], 1'b0);

    // R9 and R5: intruding line and throttle drop during a scan have no effect
    run_vec(12'hFFF, 6'd0, 3'd0, 3'd4, 16'h0DA6, 1'b1);

    // R10: reset in the middle of a scan
    for (int i = 0; i < 16; i++) in_line_data[i*32 +: 32] = word_val(i);
    in_line_addr = LINE_A; in_hint = 12'hFFF; in_byte_off = '0; in_depth = '0;
    in_valid = 1'b1; pf_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(pf_valid === 1'b1, "R8 first prefetch pending", {31'b0, pf_valid}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(pf_valid === 1'b0, "R10 mid-scan reset pf_valid", {31'b0, pf_valid}, 32'd0);
    check(in_ready === 1'b1, "R10 mid-scan reset in_ready", {31'b0, in_ready}, 32'd1);
    pf_ready = 1'b1;
    @(negedge clk);
    check(pf_valid === 1'b0, "R10 nothing left after reset", {31'b0, pf_valid}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule